// File: doc/BRIEF.md
# Cartridge CPU Register Decode and PRG Bank Mapper

This block sits on the console CPU bus of a game cartridge. It recognises register accesses through a sparse address mask, keeps sixteen 8-bit write-only control registers, and turns CPU reads in the upper half of the address space into addresses for a larger program ROM. Every register is exported as a flat vector, so the nametable, audio and video logic elsewhere on the cartridge can take its own fields. The video mode field is also given a port of its own.

The mask matches two address ranges: a high range and a low mirror. A write lands in either range. A read drives the bus only in the high range, so the cartridge never fights another driver in the low range. The only value that can be read back is a 4-bit sample from an external converter. It appears at register number 0, and the register written at number 0 is a different one. The program ROM is divided into 16 KiB banks. CPU $8000-$BFFF shows any one of those banks. CPU $C000-$DFFF shows the lower half of a bank chosen by a second register. CPU $E000-$FFFF is fixed to the upper half of the last bank, so the reset vectors can always be reached.

Top module: `cart_prg_bank`

## Requirements
- R1: A write is stored only when the write strobe is high and the address has bit 15 = 0, bit 13 = 0, bit 12 = 1 and bit 11 = 1. Address bits 3..0 select which of the 16 registers takes the data, and address bits 10..4 are ignored. Any other write leaves every register unchanged.
- R2: Writes that decode in the low mirror ($1800-$1FFF, where bit 14 = 0) are stored in the same way as writes in $5800-$5FFF.
- R3: The read data enable is high only when the read strobe is high, the address decodes as in R1, and address bit 14 = 1.
- R4: A read at register number 0 returns the 4-bit sample in bits 3..0, with bits 7..4 equal to 0. A read at any other register number returns 0, whatever has been written at that number.
- R5: The video mode output equals bits 7..6 of register 1.
- R6: When address bit 15 = 1 and bit 14 = 0, the ROM address is (register 1 bits 4..0) × 0x4000 plus CPU address bits 13..0.
- R7: When address bits 15..13 = 110, the ROM address is (register 2 bits 4..0) × 0x4000 plus CPU address bits 12..0, with ROM address bit 13 forced to 0. Bits 7..5 of register 2 have no effect.
- R8: When address bits 15..13 = 111, the ROM address is 31 × 0x4000 + 0x2000 plus CPU address bits 12..0.
- R9: The ROM enable is high only when the read strobe is high and address bit 15 = 1.
- R10: The active-low reset clears all 16 registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU address |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_wr_i | input | 1 | Write strobe, high for one cycle |
| cpu_rd_i | input | 1 | Read strobe |
| adc_i | input | 4 | Sample from the external converter |
| rd_data_o | output | 8 | Register read data |
| rd_oe_o | output | 1 | Read data driver enable |
| prg_addr_o | output | 19 | Program ROM address |
| prg_ce_o | output | 1 | Program ROM enable |
| video_mode_o | output | 2 | Video mode field |
| regs_o | output | 128 | All registers; register n is bits 8n+7..8n |

## Verification
The assertions assume that the read and write strobes are never high in the same cycle. They also assume that the address and write data stay stable for the whole cycle in which the write strobe is high. The bench meets both conditions. It changes every input on the falling clock edge and lowers the write strobe one cycle after raising it. It raises the read strobe only during read checks, and only while the write strobe is low.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int unsigned CPU_AW   = 16;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned REG_N    = 16;
  localparam int unsigned SEL_W    = $clog2(REG_N);
  localparam int unsigned BANK_W   = 5;
  localparam int unsigned ADC_W    = 4;
  localparam int unsigned WIN_LSB  = 14;
  localparam int unsigned ROM_AW   = BANK_W + WIN_LSB;
  localparam int unsigned REG_BANK_LO = 1;
  localparam int unsigned REG_BANK_HI = 2;

  typedef enum logic [1:0] {
    WIN_LO16 = 2'b00,
    WIN_LO16B = 2'b01,
    WIN_MID8 = 2'b10,
    WIN_TOP8 = 2'b11
  } cpu_win_e;
endpackage

// File: rtl/cart_reg_decode.sv
module cart_reg_decode #(
  parameter int unsigned REG_N = 16,
  parameter int unsigned SEL_W = $clog2(REG_N)
) (
  input  logic [4:0]       win_i,   // address bits 15..11
  input  logic [SEL_W-1:0] sel_i,
  input  logic             wr_i,
  input  logic             rd_i,
  output logic [REG_N-1:0] wr_en_o,
  output logic             rd_oe_o
);
  logic hit;

  // mask: bit15=0, bit13=0, bit12=1, bit11=1; bit14 picks the high range
  assign hit     = ~win_i[4] & ~win_i[2] & win_i[1] & win_i[0];
  assign rd_oe_o = rd_i & hit & win_i[3];

  for (genvar g = 0; g < REG_N; g++) begin : g_wen
    assign wr_en_o[g] = wr_i & hit & (sel_i == SEL_W'(g));
  end
endmodule

// File: rtl/cart_reg_file.sv
module cart_reg_file #(
  parameter int unsigned REG_N = 16,
  parameter int unsigned REG_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [REG_N-1:0]       wr_en_i,
  input  logic [REG_W-1:0]       wdata_i,
  output logic [REG_N*REG_W-1:0] regs_o
);
  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    logic [REG_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q <= '0;
      else if (wr_en_i[g]) q <= wdata_i;
    end
    assign regs_o[g*REG_W +: REG_W] = q;
  end
endmodule

// File: rtl/cart_rd_mux.sv
module cart_rd_mux #(
  parameter int unsigned REG_W = 8,
  parameter int unsigned ADC_W = 4,
  parameter int unsigned SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             oe_i,
  input  logic [ADC_W-1:0] adc_i,
  output logic [REG_W-1:0] data_o
);
  always_comb begin
    data_o = '0;
    if (oe_i && sel_i == '0) data_o = REG_W'(adc_i);
  end
endmodule

// File: rtl/cart_prg_map.sv
module cart_prg_map
  import cart_bank_pkg::*;
#(
  parameter int unsigned BANK_W = 5,
  parameter int unsigned WIN_B  = 14,
  parameter int unsigned ROM_AW = BANK_W + WIN_B
) (
  input  logic [WIN_B+1:0]  addr_i,
  input  logic              rd_i,
  input  logic [BANK_W-1:0] bank_lo_i,
  input  logic [BANK_W-1:0] bank_hi_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              rom_ce_o
);
  cpu_win_e win;

  assign win      = cpu_win_e'(addr_i[WIN_B:WIN_B-1]);
  assign rom_ce_o = rd_i & addr_i[WIN_B+1];

  always_comb begin
    rom_addr_o = '0;
    if (addr_i[WIN_B+1]) begin
      unique case (win)
        WIN_LO16, WIN_LO16B: rom_addr_o = {bank_lo_i, addr_i[WIN_B-1:0]};
        // only the lower half of the chosen 16K bank is reachable
        WIN_MID8: rom_addr_o = {bank_hi_i, 1'b0, addr_i[WIN_B-2:0]};
        // fixed: upper half of the last bank
        WIN_TOP8: rom_addr_o = {{BANK_W{1'b1}}, 1'b1, addr_i[WIN_B-2:0]};
        default:  rom_addr_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/cart_prg_bank.sv
module cart_prg_bank
  import cart_bank_pkg::*;
#(
  parameter int unsigned P_REG_N  = REG_N,
  parameter int unsigned P_REG_W  = REG_W,
  parameter int unsigned P_BANK_W = BANK_W,
  parameter int unsigned P_ADC_W  = ADC_W,
  localparam int unsigned P_SEL_W  = $clog2(P_REG_N),
  localparam int unsigned P_ROM_AW = P_BANK_W + WIN_LSB
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CPU_AW-1:0]          cpu_addr_i,
  input  logic [P_REG_W-1:0]         cpu_wdata_i,
  input  logic                       cpu_wr_i,
  input  logic                       cpu_rd_i,
  input  logic [P_ADC_W-1:0]         adc_i,
  output logic [P_REG_W-1:0]         rd_data_o,
  output logic                       rd_oe_o,
  output logic [P_ROM_AW-1:0]        prg_addr_o,
  output logic                       prg_ce_o,
  output logic [1:0]                 video_mode_o,
  output logic [P_REG_N*P_REG_W-1:0] regs_o
);
  logic [P_REG_N-1:0] wr_en;

  cart_reg_decode #(.REG_N(P_REG_N), .SEL_W(P_SEL_W)) u_dec (
    .win_i   (cpu_addr_i[15:11]),
    .sel_i   (cpu_addr_i[P_SEL_W-1:0]),
    .wr_i    (cpu_wr_i),
    .rd_i    (cpu_rd_i),
    .wr_en_o (wr_en),
    .rd_oe_o (rd_oe_o)
  );

  cart_reg_file #(.REG_N(P_REG_N), .REG_W(P_REG_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wdata_i (cpu_wdata_i),
    .regs_o  (regs_o)
  );

  cart_rd_mux #(.REG_W(P_REG_W), .ADC_W(P_ADC_W), .SEL_W(P_SEL_W)) u_rd (
    .sel_i  (cpu_addr_i[P_SEL_W-1:0]),
    .oe_i   (rd_oe_o),
    .adc_i  (adc_i),
    .data_o (rd_data_o)
  );

  cart_prg_map #(.BANK_W(P_BANK_W), .WIN_B(WIN_LSB), .ROM_AW(P_ROM_AW)) u_map (
    .addr_i     (cpu_addr_i[WIN_LSB+1:0]),
    .rd_i       (cpu_rd_i),
    .bank_lo_i  (regs_o[REG_BANK_LO*P_REG_W +: P_BANK_W]),
    .bank_hi_i  (regs_o[REG_BANK_HI*P_REG_W +: P_BANK_W]),
    .rom_addr_o (prg_addr_o),
    .rom_ce_o   (prg_ce_o)
  );

  assign video_mode_o = regs_o[REG_BANK_LO*P_REG_W + P_REG_W-2 +: 2];
endmodule

// File: rtl/cart_prg_bank_chk.sv
module cart_prg_bank_chk #(
  parameter int unsigned REG_N  = 16,
  parameter int unsigned REG_W  = 8,
  parameter int unsigned ROM_AW = 19,
  parameter int unsigned BANK_W = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [15:0]             cpu_addr_i,
  input logic                    cpu_wr_i,
  input logic                    cpu_rd_i,
  input logic [REG_W-1:0]        rd_data_o,
  input logic                    rd_oe_o,
  input logic [ROM_AW-1:0]       prg_addr_o,
  input logic                    prg_ce_o,
  input logic [REG_N*REG_W-1:0]  regs_o
);
  logic wr_hit;
  assign wr_hit = cpu_wr_i && !cpu_addr_i[15] && !cpu_addr_i[13]
                  && cpu_addr_i[12] && cpu_addr_i[11];

  a_r1_no_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(regs_o));

  a_r3_oe_high_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> (cpu_rd_i && cpu_addr_i[14] && !cpu_addr_i[15]));

  a_r4_upper_nibble_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_o |-> (rd_data_o[REG_W-1:4] == '0));

  a_r7_mid_bit13_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b110) |-> !prg_addr_o[13]);

  a_r8_top_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b111) |-> (prg_addr_o[ROM_AW-1:13] == '1));

  a_r9_ce_upper_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prg_ce_o |-> (cpu_rd_i && cpu_addr_i[15]));
endmodule

bind cart_prg_bank cart_prg_bank_chk #(
  .REG_N(P_REG_N), .REG_W(P_REG_W), .ROM_AW(P_ROM_AW), .BANK_W(P_BANK_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr_i), .cpu_wr_i(cpu_wr_i),
  .cpu_rd_i(cpu_rd_i), .rd_data_o(rd_data_o), .rd_oe_o(rd_oe_o),
  .prg_addr_o(prg_addr_o), .prg_ce_o(prg_ce_o), .regs_o(regs_o)
);

// File: tb/cart_prg_bank_tb_top.sv
module cart_prg_bank_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [15:0]  cpu_addr_i = '0;
  logic [7:0]   cpu_wdata_i = '0;
  logic         cpu_wr_i = 1'b0;
  logic         cpu_rd_i = 1'b0;
  logic [3:0]   adc_i = '0;
  logic [7:0]   rd_data_o;
  logic         rd_oe_o;
  logic [18:0]  prg_addr_o;
  logic         prg_ce_o;
  logic [1:0]   video_mode_o;
  logic [127:0] regs_o;

  always #10 clk_i = ~clk_i;

  cart_prg_bank dut_i (.*);

  typedef struct {
    string       req;
    int          sel;   // 0 data, 1 oe, 2 rom addr, 3 ce, 4 video, 16+n reg n
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  event  chk_ev;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  logic [7:0] mdl [16];

  // monitor
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0: act = 32'(rd_data_o);
          1: act = 32'(rd_oe_o);
          2: act = 32'(prg_addr_o);
          3: act = 32'(prg_ce_o);
          4: act = 32'(video_mode_o);
          default: act = 32'(regs_o[(it.sel-16)*8 +: 8]);
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(string req, int sel, logic [31:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic fire();
    #1 ->chk_ev;
    #1;
  endtask

  function automatic bit dec_hit(logic [15:0] a);
    return !a[15] && !a[13] && a[12] && a[11];
  endfunction

  task automatic cpu_write(logic [15:0] a, logic [7:0] d, bit strobe = 1'b1);
    @(negedge clk_i);
    cpu_addr_i = a; cpu_wdata_i = d; cpu_wr_i = strobe;
    if (strobe && dec_hit(a)) mdl[a[3:0]] = d;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < 16; i++) expect_v(req, 16 + i, 32'(mdl[i]));
    fire();
  endtask

  function automatic logic [31:0] exp_rom(logic [15:0] a);
    if (!a[15]) return 0;
    if (!a[14]) return 32'(mdl[1][4:0]) * 32'h4000 + 32'(a[13:0]);
    if (!a[13]) return 32'(mdl[2][4:0]) * 32'h4000 + 32'(a[12:0]);
    return 32'd31 * 32'h4000 + 32'h2000 + 32'(a[12:0]);
  endfunction

  task automatic cpu_read(string req, logic [15:0] a, bit rd = 1'b1);
    logic [31:0] ed;
    bit eoe;
    @(negedge clk_i);
    cpu_addr_i = a; cpu_rd_i = rd;
    eoe = rd && dec_hit(a) && a[14];
    ed  = (eoe && a[3:0] == 4'd0) ? 32'(adc_i) : 32'd0;
    expect_v(req, 1, 32'(eoe));
    expect_v(req, 0, ed);
    expect_v(req, 3, 32'(rd && a[15]));
    if (a[15]) expect_v(req, 2, exp_rom(a));
    fire();
    @(negedge clk_i);
    cpu_rd_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk_i);
    check_regs("R10 reset state");
    rst_ni = 1'b1;
    @(negedge clk_i);
    expect_v("R3 idle oe", 1, 0);
    expect_v("R9 idle ce", 3, 0);
    fire();

    // R5 R6 bank and video mode
    cpu_write(16'h5801, 8'hC5);
    expect_v("R5 video mode", 4, 32'd3);
    fire();
    check_regs("R1 write reg1");
    cpu_read("R6 low window", 16'h8123);
    cpu_read("R6 low window top", 16'hBFFF);

    // R2 mirror write, R7 mid window
    cpu_write(16'h1802, 8'hF3);
    check_regs("R2 mirror write");
    cpu_read("R7 mid window", 16'hC456);
    cpu_read("R7 bit13 forced low", 16'hD456);
    cpu_read("R8 fixed top", 16'hE789);
    cpu_read("R8 fixed top vector", 16'hFFFC);

    // R1 decode corner cases
    cpu_write(16'h7FF3, 8'hAA);
    cpu_write(16'hD803, 8'hBB);
    cpu_write(16'h5003, 8'hCC);
    cpu_write(16'h5803, 8'hDD, 1'b0);
    check_regs("R1 unhit or unstrobed write ignored");
    cpu_write(16'h5FF3, 8'h5A);
    check_regs("R1 bits 10..4 ignored");
    cpu_write(16'h1FFF, 8'hFF);
    cpu_write(16'h5800, 8'h81);
    check_regs("R1 R2 reg15 and reg0");

    // R3 R4 reads
    adc_i = 4'h9;
    cpu_read("R4 sample read", 16'h5800);
    adc_i = 4'hF;
    cpu_read("R4 sample read upper mirror", 16'h5FF0);
    cpu_read("R3 low mirror read not driven", 16'h1800);
    cpu_read("R4 reg1 reads zero", 16'h5801);
    cpu_read("R3 unhit read", 16'h7800);
    cpu_read("R9 no strobe", 16'h8000, 1'b0);
    cpu_read("R9 low half read", 16'h6000);

    cpu_write(16'h5801, 8'h1F);
    expect_v("R5 video mode cleared", 4, 32'd0);
    fire();
    cpu_read("R6 last bank low window", 16'h8001);
    cpu_write(16'h5802, 8'h00);
    cpu_read("R7 bank zero", 16'hDFFF);

    // R10 reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    check_regs("R10 reset clears");
    expect_v("R5 video after reset", 4, 0);
    fire();
    @(negedge clk_i);
    rst_ni = 1'b1;
    cpu_read("R6 after reset", 16'h9234);

    done = 1'b1;
    @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule